// File: doc/BRIEF.md
# Packet Receive Sink (Link Side)

This block is the link-layer end of a 32-bit packet receive interface. It drives an active-low read-enable toward a PHY-layer source. It takes a word only when the source's valid strobe is high in the cycle that follows an edge at which the enable was low. Each taken word is checked for parity, framing and modulo rules. Legal words go through a small buffer to a local stream port that carries data, a byte-keep mask, first and last markers and an error flag.

Bytes are packed big-endian: the first byte of a packet sits on data bits 31:24. The end word of a packet gives its byte count through a 2-bit modulo field, and the block turns that field into a keep mask. Framing violations, modulo or abort-flag misuse and parity errors each raise a one-cycle pulse. A violation also marks the affected packet, so its end word leaves with the error flag set. Words that arrive outside any packet are discarded.

The source updates its outputs one cycle after it samples the enable. A two-entry buffer therefore absorbs the word already in flight. The enable is raised as soon as the buffer could not hold one more word.

Top module: `pkt_rx_sink`

## Requirements
- R1: After reset, `out_valid` is 0, all three error pulses are 0 and `phy_rd_en_n` is 0.
- R2: A word is taken only when `phy_vld` is high in a cycle that follows a clock edge at which `phy_rd_en_n` was 0. A word the source holds while the enable is high is not taken a second time. Taken words that are not dropped appear on the stream in arrival order with their data unchanged.
- R3: `out_keep` bit i covers `out_data[8i+7:8i]`. On a word that is not an end word, keep is 4'b1111. On an end word, modulo 0 gives 4'b1111, 1 gives 4'b1110, 2 gives 4'b1100 and 3 gives 4'b1000.
- R4: `out_first` equals the start marker of the taken word, and `out_last` equals its end marker.
- R5: `out_error` is 1 only on an end word. It is 1 when the input abort flag is set on that word or when any violation (R7, R8, R9) hit the packet.
- R6: A word taken with no packet open and no start marker is dropped, whatever its other fields. Each such word produces one `frame_err` pulse in the cycle after it is taken. Dropping continues until the next start marker.
- R7: A start marker while a packet is open produces one `frame_err` pulse. That word begins a new packet with `out_first` = 1, and the end word of the new packet carries `out_error` = 1.
- R8: A nonzero modulo, or an abort flag, on a word that is not an end word produces one `proto_err` pulse and marks the packet as errored.
- R9: With `parity_odd` = 1, the data bits plus `phy_par` must hold an odd number of ones; with `parity_odd` = 0, an even number. A word that breaks this produces one `par_err` pulse and marks the packet as errored.
- R10: The enable goes high whenever the buffer could not take another word, so no word is lost under any stall pattern. A stalled output word stays stable until it is accepted.
- R11: With `out_ready` held at 1, the enable never goes high, so one word per cycle passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| phy_rd_en_n | output | 1 | Active-low read enable to the source |
| phy_vld | input | 1 | Source valid strobe |
| phy_data | input | 32 | Source data, big-endian |
| phy_sop | input | 1 | Start-of-packet marker |
| phy_eop | input | 1 | End-of-packet marker |
| phy_err | input | 1 | Abort flag, legal on the end word only |
| phy_mod | input | 2 | End-word byte modulo |
| phy_par | input | 1 | Parity bit over `phy_data` |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | 32 | Stream data |
| out_keep | output | 4 | Stream byte-keep mask |
| out_first | output | 1 | First word of a packet |
| out_last | output | 1 | Last word of a packet |
| out_error | output | 1 | Packet is aborted or corrupted (end word only) |
| frame_err | output | 1 | Pulse: missing start or missing end |
| proto_err | output | 1 | Pulse: modulo or abort flag on a non-end word |
| par_err | output | 1 | Pulse: parity mismatch |

## Verification
The hardest case to reach is a word still in flight at the moment the buffer fills. The source must hold its outputs while the enable is high, and those held outputs must not be taken twice. The bench models the source's hold-on-enable behaviour cycle by cycle. It runs the same packet streams under four consumer patterns (always ready, alternating, pseudo-random, and a long stall followed by release), with and without idle gaps from the source. That puts both buffer entries in use at the moment the in-flight word lands.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int unsigned RX_BYTES = 4;
  localparam int unsigned RX_DW    = 8 * RX_BYTES;
  localparam int unsigned RX_MW    = (RX_BYTES > 1) ? $clog2(RX_BYTES) : 1;

  typedef struct packed {
    logic [RX_DW-1:0]    data;
    logic [RX_BYTES-1:0] keep;
    logic                first;
    logic                last;
    logic                error;
  } rx_beat_t;
endpackage

// File: rtl/pkt_rx_flow.sv
module pkt_rx_flow #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phy_vld,
  input  logic [CW-1:0] fill,
  input  logic          pop,
  output logic          rd_en_n,
  output logic          take
);
  logic        en_q;
  logic [CW:0] projected;

  // a word is real only if the enable was low at the previous edge
  always_comb begin
    take      = phy_vld && en_q;
    projected = {1'b0, fill} + (CW+1)'(take) - (CW+1)'(pop);
    rd_en_n   = projected > (CW+1)'(DEPTH - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= !rd_en_n;
  end
endmodule

// File: rtl/pkt_rx_skid.sv
module pkt_rx_skid
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_beat_t      din,
  input  logic          pop,
  output rx_beat_t      dout,
  output logic [CW-1:0] fill,
  output logic          nonempty
);
  rx_beat_t      mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] fill_q, fill_d;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      fill_d = fill_q + 1'b1;
    else if (pop && !push) fill_d = fill_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout     = mem[rd_q];
  assign fill     = fill_q;
  assign nonempty = (fill_q != '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fill_q == CW'(DEPTH)) |-> pop);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill_q != '0));
endmodule

// File: rtl/pkt_rx_frame.sv
module pkt_rx_frame
  import pkt_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parity_odd,
  input  logic             take,
  input  logic [RX_DW-1:0] data,
  input  logic             sop,
  input  logic             eop,
  input  logic             err,
  input  logic [RX_MW-1:0] mod,
  input  logic             par,
  output logic             push,
  output rx_beat_t         beat,
  output logic             frame_err,
  output logic             proto_err,
  output logic             par_err
);
  logic open_q, open_d, bad_q, bad_d;
  logic fe_q, fe_d, pe_q, pe_d, pa_q, pa_d;
  logic par_bad, proto_bad, viol, restart, orphan, carried;
  logic [RX_BYTES-1:0] keep;

  // big-endian: byte lane i is valid on the end word when i >= modulo
  for (genvar i = 0; i < RX_BYTES; i++) begin : g_keep
    assign keep[i] = !eop || (RX_MW'(i) >= mod);
  end

  always_comb begin
    par_bad   = ((^data) ^ par) != parity_odd;
    proto_bad = !eop && ((mod != '0) || err);
    viol      = proto_bad || par_bad;
    restart   = sop && open_q;
    orphan    = !sop && !open_q;
    carried   = !sop && bad_q;
    push      = take && !orphan;

    beat.data  = data;
    beat.keep  = keep;
    beat.first = sop;
    beat.last  = eop;
    beat.error = eop && (err || viol || restart || carried);

    open_d = open_q;
    bad_d  = bad_q;
    if (push) begin
      open_d = !eop;
      bad_d  = !eop && (viol || restart || carried);
    end
    fe_d = take && (restart || orphan);
    pe_d = take && proto_bad;
    pa_d = take && par_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      bad_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      pa_q   <= 1'b0;
    end else begin
      open_q <= open_d;
      bad_q  <= bad_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      pa_q   <= pa_d;
    end
  end

  assign frame_err = fe_q;
  assign proto_err = pe_q;
  assign par_err   = pa_q;

  assert_orphan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sop && !open_q) |=> (frame_err && !open_q));
  assert_bad_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> open_q);
endmodule

// File: rtl/pkt_rx_sink.sv
module pkt_rx_sink
  import pkt_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parity_odd,
  output logic             phy_rd_en_n,
  input  logic             phy_vld,
  input  logic [RX_DW-1:0] phy_data,
  input  logic             phy_sop,
  input  logic             phy_eop,
  input  logic             phy_err,
  input  logic [RX_MW-1:0] phy_mod,
  input  logic             phy_par,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RX_DW-1:0] out_data,
  output logic [RX_BYTES-1:0] out_keep,
  output logic             out_first,
  output logic             out_last,
  output logic             out_error,
  output logic             frame_err,
  output logic             proto_err,
  output logic             par_err
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          take, push, pop;
  logic [CW-1:0] fill;
  rx_beat_t      in_beat, out_beat;

  assign pop = out_valid && out_ready;

  pkt_rx_flow #(.DEPTH(DEPTH)) u_flow (
    .clk(clk), .rst_n(rst_n), .phy_vld(phy_vld), .fill(fill), .pop(pop),
    .rd_en_n(phy_rd_en_n), .take(take)
  );

  pkt_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .parity_odd(parity_odd), .take(take),
    .data(phy_data), .sop(phy_sop), .eop(phy_eop), .err(phy_err),
    .mod(phy_mod), .par(phy_par), .push(push), .beat(in_beat),
    .frame_err(frame_err), .proto_err(proto_err), .par_err(par_err)
  );

  pkt_rx_skid #(.DEPTH(DEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n), .push(push), .din(in_beat), .pop(pop),
    .dout(out_beat), .fill(fill), .nonempty(out_valid)
  );

  assign out_data  = out_beat.data;
  assign out_keep  = out_beat.keep;
  assign out_first = out_beat.first;
  assign out_last  = out_beat.last;
  assign out_error = out_beat.error;

  assert_error_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_error) |-> out_last);
  assert_keep_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (&out_keep));
  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_keep) && $stable(out_last)));
  assert_keep_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_keep[RX_BYTES-1]);
endmodule

// File: tb/pkt_rx_sink_test.sv
module pkt_rx_sink_test;
  logic        clk = 1'b0;
  logic        rst_n, parity_odd, phy_rd_en_n, phy_vld;
  logic [31:0] phy_data;
  logic        phy_sop, phy_eop, phy_err, phy_par;
  logic [1:0]  phy_mod;
  logic        out_valid, out_ready, out_first, out_last, out_error;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        frame_err, proto_err, par_err;

  always #5 clk = ~clk;

  pkt_rx_sink #(.DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .parity_odd(parity_odd), .phy_rd_en_n(phy_rd_en_n),
    .phy_vld(phy_vld), .phy_data(phy_data), .phy_sop(phy_sop), .phy_eop(phy_eop),
    .phy_err(phy_err), .phy_mod(phy_mod), .phy_par(phy_par),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_first(out_first), .out_last(out_last),
    .out_error(out_error), .frame_err(frame_err), .proto_err(proto_err),
    .par_err(par_err)
  );

  int n_chk = 0, n_bad = 0;

  bit [31:0] s_data [512];
  bit        s_sop [512], s_eop [512], s_err [512], s_pb [512];
  bit [1:0]  s_mod [512];
  int        n_s;
  bit [31:0] e_data [512];
  bit [3:0]  e_keep [512];
  bit        e_first [512], e_last [512], e_error [512];
  int        n_e;
  int        x_frame, x_proto, x_par;
  bit        m_open = 1'b0, m_bad = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic emit(input bit [31:0] d, input bit f, input bit l,
                      input bit [1:0] md, input bit e);
    e_data[n_e]  = d;
    e_keep[n_e]  = l ? 4'((4'hF << md)) : 4'hF;
    e_first[n_e] = f;
    e_last[n_e]  = l;
    e_error[n_e] = e;
    n_e++;
  endtask

  // expected stream from the requirements
  task automatic add(input bit [31:0] d, input bit sop, input bit eop, input bit err,
                     input bit [1:0] md, input bit pb);
    bit pv, viol, rs;
    s_data[n_s] = d; s_sop[n_s] = sop; s_eop[n_s] = eop;
    s_err[n_s] = err; s_mod[n_s] = md; s_pb[n_s] = pb;
    n_s++;
    pv   = !eop && ((md != 2'd0) || err);
    viol = pv || pb;
    if (pv) x_proto++;
    if (pb) x_par++;
    if (sop) begin
      rs = m_open;
      if (rs) x_frame++;
      emit(d, 1'b1, eop, md, eop && (err || viol || rs));
      m_bad  = !eop && (viol || rs);
      m_open = !eop;
    end else if (!m_open) begin
      x_frame++;
    end else begin
      emit(d, 1'b0, eop, md, eop && (err || viol || m_bad));
      m_bad  = !eop && (m_bad || viol);
      m_open = !eop;
    end
  endtask

  task automatic clear_stream();
    n_s = 0; n_e = 0; x_frame = 0; x_proto = 0; x_par = 0;
  endtask

  // sweep: modulo x abort x bad parity x length
  task automatic build_sweep(input bit [7:0] seed);
    int k;
    clear_stream();
    k = 0;
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int pb = 0; pb < 2; pb++)
          for (int len = 1; len <= 3; len++)
            for (int w = 0; w < len; w++) begin
              add({seed, 8'(m * 16 + e * 8 + pb * 4 + len), 8'(w), 8'(k)},
                  w == 0, w == len - 1, e != 0 && w == len - 1,
                  (w == len - 1) ? 2'(m) : 2'd0, pb != 0 && w == 0);
              k++;
            end
  endtask

  // framing and protocol violations
  task automatic build_faults();
    clear_stream();
    add(32'hDEAD0001, 0, 0, 0, 0, 0);  // orphan
    add(32'hDEAD0002, 0, 1, 1, 3, 1);  // orphan end word
    add(32'h11110001, 1, 0, 0, 0, 0);
    add(32'h11110002, 0, 0, 0, 0, 0);
    add(32'h22220001, 1, 0, 0, 0, 0);  // start while open
    add(32'h22220002, 0, 1, 0, 1, 0);
    add(32'h33330001, 1, 0, 0, 2, 0);  // modulo on non-end word
    add(32'h33330002, 0, 1, 0, 0, 0);
    add(32'h44440001, 1, 0, 1, 0, 0);  // abort on non-end word
    add(32'h44440002, 0, 0, 0, 0, 0);
    add(32'h44440003, 0, 1, 0, 2, 0);
    add(32'h55550001, 1, 1, 0, 3, 0);  // single word
    add(32'h66660001, 1, 1, 1, 0, 0);  // aborted single word
    add(32'hDEAD0003, 0, 0, 0, 0, 0);  // orphan
    add(32'h77770001, 1, 0, 0, 0, 0);
    add(32'h77770002, 0, 0, 0, 0, 1);  // parity on middle word
    add(32'h77770003, 0, 1, 0, 0, 0);
  endtask

  task automatic run(input int rmode, input bit gaps, input string tag);
    int idx, oidx, cyc, idle, fr, pr, pa, hi;
    bit en_smp;
    logic [15:0] lf;
    idx = 0; oidx = 0; cyc = 0; idle = 0; fr = 0; pr = 0; pa = 0; hi = 0;
    lf = 16'hACE1 ^ 16'(rmode * 77 + 5);
    while (1) begin
      @(negedge clk);
      en_smp = !phy_rd_en_n;
      if (phy_rd_en_n) hi++;
      if (rmode == 3 && cyc == 30)
        chk(phy_rd_en_n == 1'b1, {"R10 enable high while stalled ", tag}, phy_rd_en_n, 1);
      fr += int'(frame_err); pr += int'(proto_err); pa += int'(par_err);
      if (out_valid && out_ready) begin
        if (oidx < n_e) begin
          chk(out_data == e_data[oidx], {"R2 data ", tag}, out_data, e_data[oidx]);
          chk(out_keep == e_keep[oidx], {"R3 keep ", tag}, out_keep, e_keep[oidx]);
          chk(out_first == e_first[oidx], {"R4 first ", tag}, out_first, e_first[oidx]);
          chk(out_last == e_last[oidx], {"R4 last ", tag}, out_last, e_last[oidx]);
          chk(out_error == e_error[oidx], {"R5 error ", tag}, out_error, e_error[oidx]);
        end else begin
          chk(1'b0, {"R2 extra word ", tag}, oidx, n_e);
        end
        oidx++;
      end
      if (idx == n_s && !out_valid && !phy_vld) idle++;
      else idle = 0;
      if (idle > 4) break;
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, {"watchdog ", tag}, cyc, 0);
        break;
      end
      @(posedge clk);
      #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (en_smp) begin
        if (idx < n_s && !(gaps && lf[0])) begin
          phy_vld  = 1'b1;
          phy_data = s_data[idx];
          phy_sop  = s_sop[idx];
          phy_eop  = s_eop[idx];
          phy_err  = s_err[idx];
          phy_mod  = s_mod[idx];
          phy_par  = (^s_data[idx]) ^ parity_odd ^ s_pb[idx];
          idx++;
        end else begin
          phy_vld = 1'b0;
        end
      end
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        2: out_ready = lf[3] | lf[7];
        default: out_ready = (cyc >= 40);
      endcase
    end
    chk(oidx == n_e, {"R2 word count ", tag}, oidx, n_e);
    chk(fr == x_frame, {"R6 R7 frame pulses ", tag}, fr, x_frame);
    chk(pr == x_proto, {"R8 protocol pulses ", tag}, pr, x_proto);
    chk(pa == x_par, {"R9 parity pulses ", tag}, pa, x_par);
    if (rmode == 0 && !gaps)
      chk(hi == 0, {"R11 enable stays low ", tag}, hi, 0);
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog global", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; parity_odd = 1'b0; out_ready = 1'b1;
    phy_vld = 1'b0; phy_data = '0; phy_sop = 1'b0; phy_eop = 1'b0;
    phy_err = 1'b0; phy_mod = '0; phy_par = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(phy_rd_en_n == 1'b0, "R1 enable after reset", phy_rd_en_n, 0);
    chk({frame_err, proto_err, par_err} == 3'b000, "R1 pulses after reset",
        {frame_err, proto_err, par_err}, 0);

    build_sweep(8'hA1); run(0, 1'b0, "sweep ready even");
    parity_odd = 1'b1;
    build_sweep(8'hB2); run(1, 1'b1, "sweep alternate odd");
    build_sweep(8'hC3); run(3, 1'b0, "sweep stall odd");
    build_faults();     run(2, 1'b1, "faults random odd");
    parity_odd = 1'b0;
    build_faults();     run(3, 1'b1, "faults stall even");
    build_faults();     run(0, 1'b0, "faults ready even");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule